// File: doc/BRIEF.md
# Pixel Clock Ratio Search Engine

This block picks the integer multiplier P and divider Q for a pixel clock synthesizer. Given a requested output frequency in hertz, it searches for the pair whose value reference * P / Q lands closest to the request. The reference is fixed at 14318180 Hz. No divider, multiplier or lookup table is used. The engine walks Q upward from 1. For each Q it builds the term target*Q by accumulation, then counts P up by subtracting the reference one step per cycle until the residual is no longer positive.

Software or a mode-setting state machine writes the target, pulses start and waits for done. It then reads P, Q and the absolute residual |target*Q - reference*P|. A search takes a few thousand cycles at most. The done flag stays high, with stable results, until the next start.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy_o and done_o are 0, p_o and q_o are 0, and err_o is all ones (48 bits).
- R2: A start_i pulse while the engine is not busy begins a search. In the next cycle busy_o is 1 and done_o is 0.
- R3: Q is tried in ascending order from 1 to 63 with a reference of 14318180. For each Q, P starts at 1, and the residual target*Q - 14318180*P is lowered by one reference (P incremented) while it is positive and P is below 255.
- R4: If the residual is then negative, its magnitude exceeds floor(target/2), and P is above 1, P is decremented and the reference is added back.
- R5: A candidate replaces the kept result when its absolute residual is less than or equal to the best so far, so equal residuals resolve to the larger Q.
- R6: A candidate with zero residual ends the search at once, with that P and Q.
- R7: If P reaches 255 while the residual is still positive, the search ends and that Q is not taken as a candidate.
- R8: If a search ends with no candidate taken, the results are p_o=0, q_o=0 and err_o all ones.
- R9: done_o stays 1, and p_o, q_o and err_o stay unchanged, until the next start_i.
- R10: start_i is ignored while busy_o is 1, and the running search completes for its original target.
- R11: When a candidate exists, p_o is in 1..255, q_o is in 1..63, and err_o equals |target*q_o - 14318180*p_o|, the smallest such value over the Q values visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; sampled only when not busy |
| target_i | input | 32 | Requested frequency in Hz, captured at start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid; held until next start |
| p_o | output | 8 | Chosen multiplier P |
| q_o | output | 6 | Chosen divider Q |
| err_o | output | 48 | Absolute residual of the chosen pair |

## Verification
Exact multiples of the reference (3x and 2.5x) show whether the zero-residual exit fires at Q=1 and at a later Q. A target of 1.2x reference shows the backward rounding step. A target of zero makes every Q tie, which exposes the tie rule. An all-ones target saturates P at Q=1 and shows the no-candidate result. A typical video frequency, compared against an independent model of the search, shows the full sweep. A second start during a search shows whether start requests are ignored while busy.

// File: rtl/pll_div_search_pkg.sv
package pll_div_search_pkg;
  localparam int unsigned REF_HZ_DEF = 14318180;
  localparam int unsigned P_MAX_DEF  = 255;
  localparam int unsigned Q_MAX_DEF  = 63;
  localparam int unsigned F_W_DEF    = 32;
  localparam int unsigned ERR_W_DEF  = 48;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_WALK,
    S_JUDGE,
    S_DONE
  } srch_state_t;
endpackage

// File: rtl/pll_q_sweep.sv
module pll_q_sweep #(
  parameter int unsigned F_W   = 32,
  parameter int unsigned ERR_W = 48,
  parameter int unsigned Q_MAX = 63,
  localparam int unsigned Q_W  = $clog2(Q_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             next,
  input  logic [F_W-1:0]   target,
  input  logic [F_W-1:0]   target_hold,
  output logic [Q_W-1:0]   q_val,
  output logic [ERR_W-1:0] fq_val,
  output logic             q_last
);
  // fq_val tracks target*q by accumulation, so no multiplier is needed.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_val  <= '0;
      fq_val <= '0;
    end else if (init) begin
      q_val  <= Q_W'(1);
      fq_val <= ERR_W'(target);
    end else if (next) begin
      q_val  <= q_val + Q_W'(1);
      fq_val <= fq_val + ERR_W'(target_hold);
    end
  end

  assign q_last = (q_val == Q_W'(Q_MAX));
endmodule

// File: rtl/pll_p_walk.sv
module pll_p_walk #(
  parameter int unsigned ERR_W  = 48,
  parameter int unsigned P_MAX  = 255,
  parameter int unsigned REF_HZ = 14318180,
  localparam int unsigned P_W   = $clog2(P_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [ERR_W-1:0] fq,
  input  logic [ERR_W-1:0] half,
  output logic             l_pos,
  output logic             p_at_max,
  output logic [P_W-1:0]   cand_p,
  output logic [ERR_W-1:0] cand_err
);
  localparam logic [ERR_W-1:0] REF_V = ERR_W'(REF_HZ);

  logic signed [ERR_W-1:0] l_r;
  logic        [P_W-1:0]   p_r;
  logic        [ERR_W-1:0] neg_mag;
  logic                    back;
  logic signed [ERR_W-1:0] l_adj;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_r <= '0;
      p_r <= '0;
    end else if (load) begin
      l_r <= $signed(fq - REF_V);
      p_r <= P_W'(1);
    end else if (step) begin
      l_r <= l_r - $signed(REF_V);
      p_r <= p_r + P_W'(1);
    end
  end

  assign l_pos    = !l_r[ERR_W-1] && (l_r != '0);
  assign p_at_max = (p_r == P_W'(P_MAX));

  // Step back one reference when the overshoot is larger than half the target.
  always_comb begin
    neg_mag  = $unsigned(-l_r);
    back     = l_r[ERR_W-1] && (neg_mag > half) && (p_r > P_W'(1));
    l_adj    = back ? (l_r + $signed(REF_V)) : l_r;
    cand_p   = back ? (p_r - P_W'(1)) : p_r;
    cand_err = l_adj[ERR_W-1] ? $unsigned(-l_adj) : $unsigned(l_adj);
  end
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int unsigned ERR_W = 48,
  parameter int unsigned P_W   = 8,
  parameter int unsigned Q_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             judge,
  input  logic [ERR_W-1:0] cand_err,
  input  logic [P_W-1:0]   cand_p,
  input  logic [Q_W-1:0]   cand_q,
  output logic [ERR_W-1:0] best_err,
  output logic [P_W-1:0]   best_p,
  output logic [Q_W-1:0]   best_q
);
  logic take;
  // Less-or-equal lets a later Q win a tie.
  assign take = judge && (cand_err <= best_err);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      best_err <= '1;
      best_p   <= '0;
      best_q   <= '0;
    end else if (take) begin
      best_err <= cand_err;
      best_p   <= cand_p;
      best_q   <= cand_q;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_search_pkg::*;
#(
  parameter int unsigned REF_HZ = REF_HZ_DEF,
  parameter int unsigned P_MAX  = P_MAX_DEF,
  parameter int unsigned Q_MAX  = Q_MAX_DEF,
  parameter int unsigned F_W    = F_W_DEF,
  parameter int unsigned ERR_W  = ERR_W_DEF,
  localparam int unsigned P_W   = $clog2(P_MAX + 1),
  localparam int unsigned Q_W   = $clog2(Q_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [F_W-1:0]   target_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [P_W-1:0]   p_o,
  output logic [Q_W-1:0]   q_o,
  output logic [ERR_W-1:0] err_o
);
  srch_state_t state_r;
  logic [F_W-1:0]   target_r;
  logic             accept;
  logic [Q_W-1:0]   q_val;
  logic [ERR_W-1:0] fq_val;
  logic             q_last;
  logic             l_pos, p_at_max;
  logic [P_W-1:0]   cand_p;
  logic [ERR_W-1:0] cand_err;
  logic             in_walk, in_load, in_judge;
  logic             do_step, do_next;

  assign accept   = start_i && ((state_r == S_IDLE) || (state_r == S_DONE));
  assign in_walk  = (state_r == S_WALK);
  assign in_load  = (state_r == S_LOAD);
  assign in_judge = (state_r == S_JUDGE);
  assign do_step  = in_walk && l_pos && !p_at_max;
  assign do_next  = in_judge && (cand_err != '0) && !q_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r  <= S_IDLE;
      target_r <= '0;
    end else begin
      if (accept) target_r <= target_i;
      unique case (state_r)
        S_IDLE, S_DONE: if (accept) state_r <= S_LOAD;
        S_LOAD:         state_r <= S_WALK;
        S_WALK: begin
          if (l_pos && p_at_max) state_r <= S_DONE;
          else if (!l_pos)       state_r <= S_JUDGE;
        end
        S_JUDGE:        state_r <= do_next ? S_LOAD : S_DONE;
        default:        state_r <= S_IDLE;
      endcase
    end
  end

  pll_q_sweep #(.F_W(F_W), .ERR_W(ERR_W), .Q_MAX(Q_MAX)) u_sweep (
    .clk(clk), .rst(rst), .init(accept), .next(do_next),
    .target(target_i), .target_hold(target_r),
    .q_val(q_val), .fq_val(fq_val), .q_last(q_last)
  );

  pll_p_walk #(.ERR_W(ERR_W), .P_MAX(P_MAX), .REF_HZ(REF_HZ)) u_walk (
    .clk(clk), .rst(rst), .load(in_load), .step(do_step),
    .fq(fq_val), .half(ERR_W'(target_r >> 1)),
    .l_pos(l_pos), .p_at_max(p_at_max),
    .cand_p(cand_p), .cand_err(cand_err)
  );

  pll_best_keep #(.ERR_W(ERR_W), .P_W(P_W), .Q_W(Q_W)) u_best (
    .clk(clk), .rst(rst), .init(accept), .judge(in_judge),
    .cand_err(cand_err), .cand_p(cand_p), .cand_q(q_val),
    .best_err(err_o), .best_p(p_o), .best_q(q_o)
  );

  assign busy_o = (state_r == S_LOAD) || in_walk || in_judge;
  assign done_o = (state_r == S_DONE);
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int unsigned P_W   = 8,
  parameter int unsigned Q_W   = 6,
  parameter int unsigned ERR_W = 48,
  parameter int unsigned P_MAX = 255,
  parameter int unsigned Q_MAX = 63
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [P_W-1:0]   p_o,
  input logic [Q_W-1:0]   q_o,
  input logic [ERR_W-1:0] err_o
);
  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  p_start_go_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (busy_o && !done_o));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(p_o) && $stable(q_o) && $stable(err_o)));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !$past(rst)) |=> (busy_o || done_o));

  p_mono_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !$past(rst)) |-> (err_o <= $past(err_o)));

  p_none_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && (q_o == '0)) |-> ((p_o == '0) && (err_o == '1)));

  p_range_r11: assert property (@(posedge clk) disable iff (rst)
    (done_o && (q_o != '0)) |->
      ((p_o >= P_W'(1)) && (p_o <= P_W'(P_MAX)) && (q_o <= Q_W'(Q_MAX))));
endmodule

bind pll_div_search pll_div_search_chk #(
  .P_W(P_W), .Q_W(Q_W), .ERR_W(ERR_W), .P_MAX(P_MAX), .Q_MAX(Q_MAX)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .p_o(p_o), .q_o(q_o), .err_o(err_o)
);

// File: tb/pll_div_search_tb_top.sv
module pll_div_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint REFV = 14318180;
  localparam longint ALL1 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] target_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  p_o;
  logic [5:0]  q_o;
  logic [47:0] err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pll_div_search dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
    .busy_o(busy_o), .done_o(done_o), .p_o(p_o), .q_o(q_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent search model written from R3..R8.
  task automatic model(input longint f, output longint ep, output longint eq, output longint ee);
    ee = ALL1; ep = 0; eq = 0;
    for (int q = 1; q <= 63; q++) begin
      longint l, p, a;
      l = f * q - REFV; p = 1;
      while (l > 0 && p < 255) begin l = l - REFV; p++; end
      if (l > 0) break;
      if ((-l) > (f >> 1) && p > 1) begin l = l + REFV; p--; end
      a = (l < 0) ? -l : l;
      if (a <= ee) begin ee = a; ep = p; eq = q; end
      if (a == 0) break;
    end
  endtask

  task automatic run(input longint f);
    @(negedge clk);
    target_i = f[31:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R2", longint'(busy_o), 1);
    while (!done_o) @(negedge clk);
  endtask

  task automatic expect_res(input string req, input longint ep, input longint eq, input longint ee);
    chk(p_o == ep[7:0], req, longint'(p_o), ep);
    chk(q_o == eq[5:0], req, longint'(q_o), eq);
    chk(err_o == ee[47:0], req, longint'(err_o), ee);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o, "R1", longint'({busy_o, done_o}), 0);
    expect_res("R1", 0, 0, ALL1);
  endtask

  task automatic t_exact_q1();   // R6, R3: 3x reference exits at Q=1
    run(3 * REFV);
    expect_res("R6", 3, 1, 0);
  endtask

  task automatic t_exact_later(); // R6: 2.5x reference first exact at Q=2
    run(35795450);
    expect_res("R6", 5, 2, 0);
  endtask

  task automatic t_round();      // R4: 1.2x reference
    longint ep, eq, ee;
    model(17181816, ep, eq, ee);
    run(17181816);
    expect_res("R4", ep, eq, ee);
    expect_res("R4", 6, 5, 0);
  endtask

  task automatic t_ties();       // R5: target 0, every Q ties
    run(0);
    expect_res("R5", 1, 63, REFV);
  endtask

  task automatic t_saturate();   // R7, R8
    run(64'hFFFF_FFFF);
    expect_res("R7", 0, 0, ALL1);
    chk(done_o, "R8", longint'(done_o), 1);
  endtask

  task automatic t_typical(input longint f); // R3, R11
    longint ep, eq, ee, resid;
    model(f, ep, eq, ee);
    run(f);
    expect_res("R3", ep, eq, ee);
    resid = f * longint'(q_o) - REFV * longint'(p_o);
    if (resid < 0) resid = -resid;
    chk(longint'(err_o) == resid, "R11", longint'(err_o), resid);
  endtask

  task automatic t_hold();       // R9
    longint sp, sq, se;
    sp = longint'(p_o); sq = longint'(q_o); se = longint'(err_o);
    repeat (20) @(negedge clk);
    chk(done_o, "R9", longint'(done_o), 1);
    expect_res("R9", sp, sq, se);
  endtask

  task automatic t_busy_ignore(); // R10
    longint ep, eq, ee;
    model(25175000, ep, eq, ee);
    @(negedge clk);
    target_i = 25175000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o, "R10", longint'(busy_o), 1);
    target_i = 32'(3 * REFV); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    expect_res("R10", ep, eq, ee);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_exact_q1();
    t_hold();
    t_exact_later();
    t_round();
    t_ties();
    t_saturate();
    t_typical(25175000);
    t_typical(65000000);
    t_typical(7000000);
    t_busy_ignore();
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule